// File: doc/BRIEF.md
# Masked I2C Slave Address Comparator

This block decides whether an address received on an I2C bus belongs to this slave. The serial front end delivers each received byte on a small valid/ready stream. A flag marks the first address byte after a start condition, and a bus-event pin reports start and stop conditions. The comparator checks the byte against a stored own-address register. A per-bit mask register can turn chosen address bits into don't-cares, so one slave can answer to a group of addresses.

A four-bit mode field selects how addresses are matched. Code 0110 selects 7-bit addressing and code 0111 selects 10-bit addressing; every other code disables matching. In 10-bit mode the first byte must carry the fixed 11110 prefix and the two upper address bits, and that byte is never masked. A hit on the first byte arms the block, and the masked low byte completes the match. Software loads both registers through a plain register port. While the mode field holds 1001, the address location of that port reaches the mask register instead. A match is reported as a single-cycle pulse.

The stream input has no back-pressure once the block is out of reset: rx_ready is held high and every byte offered with rx_valid is taken in the same cycle. During reset rx_ready is low, and bytes offered then are dropped.

Top module: `masked_addr_cmp`

## Requirements
- R1: A mask bit of 0 makes the received bit at that position a don't-care. A mask bit of 1 requires the received bit to equal the own-address bit at that position.
- R2: After reset the mask register reads 8'hFF, both own-address locations read 8'h00, addr_match is low and rx_ready is low until the first clock edge after reset is released.
- R3: In mode 0110, a byte taken with rx_first=1 is compared on bits 7..1 only. Bit 0 (read/write) and mask bit 0 have no effect. A hit raises addr_match for exactly the one cycle after the byte is taken.
- R4: In mode 0110, bytes taken with rx_first=0 never produce a match.
- R5: In mode 0111, a byte taken with rx_first=1 hits only if bits 7..3 equal 11110 and bits 2..1 equal own-address bits 9..8. No masking is applied and bit 0 is ignored. A hit arms the block; a miss disarms it. No pulse is produced for this byte.
- R6: In mode 0111, a byte taken with rx_first=0 while armed is compared on all bits 7..0 under the full mask, including mask bit 0. A hit raises addr_match for the one cycle after the byte is taken. The block disarms whether or not the byte hits.
- R7: In mode 0111, bus_evt=1 disarms the block and any byte offered in the same cycle is not evaluated. A low byte that arrives while disarmed gives no pulse.
- R8: Under any mode code other than 0110 or 0111, addr_match stays low and the armed state is cleared.
- R9: Register port: reg_sel=0 selects own-address bits 7..0 and reg_sel=1 selects the upper byte, whose bits 1..0 are own-address bits 9..8. Writes take effect at the clock edge on which reg_wr=1. reg_rdata shows the selected location combinationally. While mode is 1001, reg_sel=0 reads and writes the mask register instead, and the own-address byte is left untouched.
- R10: rx_ready is high in every cycle after the first clock edge following reset release, and a byte is taken whenever rx_valid and rx_ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 4 | Mode field: 0110 = 7-bit slave, 0111 = 10-bit slave, 1001 = mask access |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register location: 0 = low address byte or mask, 1 = upper address byte |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data of the selected location |
| rx_valid | input | 1 | Received byte is offered |
| rx_ready | output | 1 | Block accepts bytes (high after reset) |
| rx_data | input | 8 | Received byte |
| rx_first | input | 1 | Byte is the first address byte after a start condition |
| bus_evt | input | 1 | Start or stop condition seen |
| addr_match | output | 1 | One-cycle address match pulse |

## Verification
The own address is held fixed. In each mode, the received byte is taken either equal to it or with exactly one bit flipped, under a set of masks that includes all ones, all zeros, single-bit and split patterns. These cases show whether a given mask bit really releases its position, and whether bit 0 is excluded in 7-bit mode but included for the 10-bit low byte. High-byte variants sent under an all-zero mask separate the unmasked prefix check from the masked low-byte check. Bus events placed between the bytes or in the same cycle as a byte, mismatching first bytes, and mode changes in mid-transaction show that the armed state is cleared. Mask-access writes followed by reads in other modes show that the redirect leaves the own address alone.

// File: rtl/amc_pkg.sv
package amc_pkg;
  localparam logic [3:0] MODE_SLAVE7      = 4'b0110;
  localparam logic [3:0] MODE_SLAVE10     = 4'b0111;
  localparam logic [3:0] MODE_MASK_ACCESS = 4'b1001;
  localparam logic [4:0] TEN_BIT_PREFIX   = 5'b11110;

  typedef enum logic [1:0] {
    CMP_OFF   = 2'd0,
    CMP_SEVEN = 2'd1,
    CMP_TEN   = 2'd2
  } cmp_mode_e;
endpackage

// File: rtl/amc_regs.sv
module amc_regs
  import amc_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        mode,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic [BYTE_W-1:0] own_lo,
  output logic [BYTE_W-1:0] own_hi,
  output logic [BYTE_W-1:0] mask
);
  logic redirect;
  logic wr_lo, wr_hi, wr_mask;

  // mask access mode steers the low location to the mask register
  assign redirect = (mode == MODE_MASK_ACCESS);
  assign wr_mask  = reg_wr && !reg_sel && redirect;
  assign wr_lo    = reg_wr && !reg_sel && !redirect;
  assign wr_hi    = reg_wr && reg_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_lo <= '0;
      own_hi <= '0;
      mask   <= '1;
    end else begin
      if (wr_lo)   own_lo <= reg_wdata;
      if (wr_hi)   own_hi <= reg_wdata;
      if (wr_mask) mask   <= reg_wdata;
    end
  end

  always_comb begin
    if (reg_sel)       reg_rdata = own_hi;
    else if (redirect) reg_rdata = mask;
    else               reg_rdata = own_lo;
  end
endmodule

// File: rtl/amc_compare.sv
module amc_compare
  import amc_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] rx_data,
  input  logic [BYTE_W-1:0] own_lo,
  input  logic [1:0]        own_upper,
  input  logic [BYTE_W-1:0] mask,
  output logic              hit7,
  output logic              hit10_hi,
  output logic              hit10_lo
);
  localparam int PFX_W = BYTE_W - 3;

  logic [BYTE_W-1:0] diff;
  logic [BYTE_W-1:0] care7;
  logic [BYTE_W-1:0] care10;

  assign diff = rx_data ^ own_lo;

  // per-bit care vectors: bit 0 is the direction bit in 7-bit mode
  for (genvar i = 0; i < BYTE_W; i++) begin : g_care
    if (i == 0) begin : g_dir
      assign care7[i] = 1'b0;
    end else begin : g_addr
      assign care7[i] = mask[i];
    end
    assign care10[i] = mask[i];
  end

  assign hit7     = ~|(diff & care7);
  assign hit10_lo = ~|(diff & care10);
  assign hit10_hi = (rx_data[BYTE_W-1:3] == PFX_W'(TEN_BIT_PREFIX)) &&
                    (rx_data[2:1] == own_upper);
endmodule

// File: rtl/amc_seq.sv
module amc_seq
  import amc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mode,
  input  logic       take,
  input  logic       rx_first,
  input  logic       bus_evt,
  input  logic       hit7,
  input  logic       hit10_hi,
  input  logic       hit10_lo,
  output logic       armed,
  output logic       addr_match,
  output logic       rx_ready
);
  cmp_mode_e cm;
  logic armed_d, match_d;

  always_comb begin
    case (mode)
      MODE_SLAVE7:  cm = CMP_SEVEN;
      MODE_SLAVE10: cm = CMP_TEN;
      default:      cm = CMP_OFF;
    endcase
  end

  always_comb begin
    match_d = 1'b0;
    armed_d = armed;
    case (cm)
      CMP_SEVEN: begin
        armed_d = 1'b0;
        if (take && rx_first && hit7) match_d = 1'b1;
      end
      CMP_TEN: begin
        if (bus_evt) begin
          armed_d = 1'b0;
        end else if (take) begin
          if (rx_first) begin
            armed_d = hit10_hi;
          end else if (armed) begin
            armed_d = 1'b0;
            match_d = hit10_lo;
          end
        end
      end
      default: armed_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      addr_match <= 1'b0;
      rx_ready   <= 1'b0;
    end else begin
      armed      <= armed_d;
      addr_match <= match_d;
      rx_ready   <= 1'b1;
    end
  end
endmodule

// File: rtl/masked_addr_cmp.sv
module masked_addr_cmp
  import amc_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        mode,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_first,
  input  logic              bus_evt,
  output logic              addr_match
);
  logic [BYTE_W-1:0] own_lo, own_hi, mask;
  logic hit7, hit10_hi, hit10_lo;
  logic armed;
  logic take;

  assign take = rx_valid && rx_ready;

  amc_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .own_lo    (own_lo),
    .own_hi    (own_hi),
    .mask      (mask)
  );

  amc_compare #(.BYTE_W(BYTE_W)) u_cmp (
    .rx_data   (rx_data),
    .own_lo    (own_lo),
    .own_upper (own_hi[1:0]),
    .mask      (mask),
    .hit7      (hit7),
    .hit10_hi  (hit10_hi),
    .hit10_lo  (hit10_lo)
  );

  amc_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .take       (take),
    .rx_first   (rx_first),
    .bus_evt    (bus_evt),
    .hit7       (hit7),
    .hit10_hi   (hit10_hi),
    .hit10_lo   (hit10_lo),
    .armed      (armed),
    .addr_match (addr_match),
    .rx_ready   (rx_ready)
  );
endmodule

// File: rtl/amc_checker.sv
module amc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] mode,
  input logic       rx_valid,
  input logic       rx_first,
  input logic       bus_evt,
  input logic       rx_ready,
  input logic       armed,
  input logic       addr_match
);
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) != 4'b0110 && $past(mode) != 4'b0111) |-> !addr_match); // R8

  AST_SEVEN_FIRST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_match && $past(mode) == 4'b0110) |-> $past(rx_valid && rx_first)); // R4

  AST_TEN_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_match && $past(mode) == 4'b0111) |-> ($past(armed) && !$past(rx_first))); // R6

  AST_EVT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_evt && mode == 4'b0111) |=> !armed); // R7

  AST_ARM_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(mode == 4'b0111 && rx_valid && rx_first)); // R5

  AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> rx_ready); // R10
endmodule

bind masked_addr_cmp amc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .rx_valid   (rx_valid),
  .rx_first   (rx_first),
  .bus_evt    (bus_evt),
  .rx_ready   (rx_ready),
  .armed      (armed),
  .addr_match (addr_match)
);

// File: tb/masked_addr_cmp_bench.sv
module masked_addr_cmp_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] mode = 4'd0;
  logic       reg_wr = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       rx_valid = 1'b0;
  logic       rx_ready;
  logic [7:0] rx_data = 8'h00;
  logic       rx_first = 1'b0;
  logic       bus_evt = 1'b0;
  logic       addr_match;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit live = 1'b0;
  string cur_req = "R2";

  always #5 clk = ~clk;

  masked_addr_cmp u_masked_addr_cmp (
    .clk(clk), .rst_n(rst_n), .mode(mode), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .rx_first(rx_first),
    .bus_evt(bus_evt), .addr_match(addr_match)
  );

  // behavioural reference state
  logic [7:0] m_lo, m_hi, m_msk;
  bit m_arm, m_match;

  function automatic bit ref_ok(input logic [7:0] rx, input logic [7:0] own,
                                input logic [7:0] msk, input logic [7:0] span);
    return ((rx ^ own) & msk & span) == 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lo <= 8'h00; m_hi <= 8'h00; m_msk <= 8'hFF; m_arm <= 0; m_match <= 0;
    end else begin
      if (reg_wr) begin
        if (reg_sel) m_hi <= reg_wdata;
        else if (mode == 4'b1001) m_msk <= reg_wdata;
        else m_lo <= reg_wdata;
      end
      m_match <= 0;
      if (mode == 4'b0110) begin
        m_arm <= 0;
        if (rx_valid && rx_first && ref_ok(rx_data, m_lo, m_msk, 8'hFE)) m_match <= 1;
      end else if (mode == 4'b0111) begin
        if (bus_evt) m_arm <= 0;
        else if (rx_valid) begin
          if (rx_first)
            m_arm <= (rx_data[7:3] == 5'b11110) && (rx_data[2:1] == m_hi[1:0]);
          else if (m_arm) begin
            m_arm <= 0;
            if (ref_ok(rx_data, m_lo, m_msk, 8'hFF)) m_match <= 1;
          end
        end
      end else begin
        m_arm <= 0;
      end
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (live && !done) begin
      check(cur_req, {7'd0, addr_match}, {7'd0, m_match});
      check("R10", {7'd0, rx_ready}, 8'd1);
    end
  end

  task automatic set_mode(input logic [3:0] m);
    @(posedge clk); #1 mode = m;
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    @(posedge clk); #1 reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic rd(input bit sel, input logic [7:0] exp, input string req);
    @(posedge clk); #1 reg_sel = sel; #2 check(req, reg_rdata, exp);
  endtask

  task automatic snd(input logic [7:0] d, input bit first, input bit evt);
    @(posedge clk); #1 rx_valid = 1; rx_data = d; rx_first = first; bus_evt = evt;
    @(posedge clk); #1 rx_valid = 0; bus_evt = 0; rx_first = 0;
  endtask

  task automatic load_mask(input logic [7:0] mk, input logic [3:0] back);
    set_mode(4'b1001); wr(0, mk); set_mode(back);
  endtask

  function automatic logic [7:0] mask_pat(input int i);
    case (i)
      0: return 8'hFF; 1: return 8'hFE; 2: return 8'h7F; 3: return 8'hF0;
      4: return 8'h0F; 5: return 8'h00; 6: return 8'hA5; default: return 8'h01;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 check("R2", {7'd0, addr_match}, 8'd0);
    check("R2", {7'd0, rx_ready}, 8'd0);
    #1 rst_n = 1;
    @(posedge clk); #2 check("R2", {7'd0, rx_ready}, 8'd1);
    live = 1;

    // reset contents and register port (R2, R9)
    cur_req = "R2";
    rd(0, 8'h00, "R2");
    rd(1, 8'h00, "R2");
    set_mode(4'b1001);
    rd(0, 8'hFF, "R2");
    cur_req = "R9";
    wr(0, 8'h3C);
    rd(0, 8'h3C, "R9");
    set_mode(4'b0000);
    rd(0, 8'h00, "R9");
    wr(0, 8'h5A);
    wr(1, 8'h02);
    rd(0, 8'h5A, "R9");
    rd(1, 8'h02, "R9");
    set_mode(4'b1001);
    rd(0, 8'h3C, "R9");
    rd(1, 8'h02, "R9");
    wr(0, 8'hFF);

    // 7-bit sweep (R1, R3, R4)
    set_mode(4'b0110);
    for (int mi = 0; mi < 8; mi++) begin
      load_mask(mask_pat(mi), 4'b0110);
      for (int k = -1; k < 8; k++) begin
        logic [7:0] b;
        b = (k < 0) ? 8'h5A : (8'h5A ^ (8'h01 << k));
        cur_req = (k == 0) ? "R3" : "R1";
        snd(b, 1, 0);
        cur_req = "R4";
        snd(b, 0, 0);
      end
    end

    // 10-bit low-byte sweep (R1, R6)
    set_mode(4'b0111);
    for (int mi = 0; mi < 8; mi++) begin
      load_mask(mask_pat(mi), 4'b0111);
      for (int k = -1; k < 8; k++) begin
        cur_req = "R5";
        snd(8'hF4 | 8'(k & 1), 1, 0);
        cur_req = "R6";
        snd((k < 0) ? 8'h5A : (8'h5A ^ (8'h01 << k)), 0, 0);
      end
    end

    // high byte is never masked (R5)
    load_mask(8'h00, 4'b0111);
    for (int k = 0; k < 8; k++) begin
      cur_req = "R5";
      snd(8'hF4 ^ (8'h01 << k), 1, 0);
      snd(8'h00, 0, 0);
    end

    // disarming (R7)
    load_mask(8'hFF, 4'b0111);
    cur_req = "R7";
    snd(8'hF4, 1, 0); snd(8'h00, 0, 1); snd(8'h5A, 0, 0);
    snd(8'hF4, 1, 0); snd(8'h5A, 0, 1); snd(8'h5A, 0, 0);
    snd(8'hF4, 1, 0); snd(8'h5B, 0, 0); snd(8'h5A, 0, 0);
    snd(8'hF0, 1, 0); snd(8'h5A, 0, 0);
    snd(8'h5A, 0, 0);
    snd(8'hF4, 1, 0); snd(8'h5A, 0, 0);

    // other modes (R8)
    cur_req = "R8";
    snd(8'hF4, 1, 0);
    set_mode(4'b0000); set_mode(4'b0111);
    snd(8'h5A, 0, 0);
    foreach (mode[i]) begin
      set_mode(4'b1001 ^ (4'b0001 << i));
      snd(8'h5A, 1, 0); snd(8'hF4, 1, 0); snd(8'h5A, 0, 0);
    end
    set_mode(4'b1001);
    snd(8'h5A, 1, 0);

    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule